// File: doc/BRIEF.md
# Byte-Serial Peripheral Bus Master

This block sits between a host request port and a narrow 8-bit shared peripheral bus. The bus carries both addresses and data. Each host request names a slave, a direction, a length of one to four bytes, a 3-bit control code and a data word. The master breaks the word into single-byte transfers, least significant byte first. For each byte it drives one active-low chip enable, the direction line and the control lines. On reads it rebuilds the word from the bytes the slave returns.

Three slaves share the bus. The fast slave is clock-synchronous, so it keeps its enable low for a whole burst. The slow slave registers each byte on its enable strobe, so it needs a fresh enable pulse for every byte. The boot memory is read-only and uses the same data lines. Neither the slow slave nor the boot memory signals completion. The master therefore holds every byte for a fixed, per-slave number of clocks.

The control code is passed through untouched. The host uses it to mark direct and indirect accesses. An indirect access is preceded by a write with code 000 that loads the slave's pointer. On the bus this write is an ordinary write request.

Top module: `pbus_master`

## Requirements
- R1: `req_ready` is high exactly when the master is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While a request is in progress, `req_valid` and the request fields have no effect on any output.
- R2: A write keeps `bus_rd` low and `bus_oe` high. It puts byte k of `req_wdata` (bits 8k+7:8k) on `bus_dout` for the whole window of byte k. Bytes go out in the order 0, 1, 2, 3, and `req_len` holds the number of bytes minus one.
- R3: At most one chip enable is low at any time. `req_sel` 0 selects `ce_fast_n`, 1 selects `ce_slow_n`, and 2 or 3 select `ce_boot_n`. The selected enable is low only during byte windows.
- R4: For the fast slave, the enable stays low without a break from the first byte window to the last, and the windows follow each other with no gap.
- R5: For the slow slave and the boot memory, all enables are high for exactly one clock between two byte windows.
- R6: A byte window lasts WAIT_FAST clocks (default 1) on the fast slave, WAIT_SLOW (default 4) on the slow slave and WAIT_BOOT (default 8) on the boot memory.
- R7: A read spends one clock with `bus_oe` and `bus_rd` both low before `bus_rd` rises. After the last byte it spends one clock with both low, then returns to idle with `bus_oe` high. `bus_oe` and `bus_rd` are never high together.
- R8: On a read, `bus_din` is sampled on the last clock of each byte window into bits 8k+7:8k of `rsp_rdata`. Bytes beyond the length read as zero, and a write returns zero.
- R9: `rsp_done` is a one-clock pulse in the clock after the last byte window. For a write this is an idle clock, so the next request may be taken in the same clock.
- R10: A request to the boot memory is always performed as a read, whatever `req_rd` says.
- R11: `bus_ctl` shows the control code of the request, including code 000, during every byte window of that request.
- R12: While reset is active and immediately after it, all enables are high, `bus_rd` is low, `bus_oe` is high, `req_ready` is high and `rsp_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Master idle, request can be taken |
| req_sel | input | 2 | Slave select: 0 fast, 1 slow, 2/3 boot memory |
| req_rd | input | 1 | 1 read, 0 write |
| req_len | input | 2 | Number of bytes minus one |
| req_ctl | input | 3 | Control code passed to the bus |
| req_wdata | input | 32 | Write word |
| rsp_done | output | 1 | Request finished (one clock) |
| rsp_rdata | output | 32 | Assembled read word |
| bus_dout | output | 8 | Data driven to the bus |
| bus_din | input | 8 | Data returned from the bus |
| bus_oe | output | 1 | Master drives the data lines |
| bus_rd | output | 1 | Direction: high read, low write |
| bus_ctl | output | 3 | Control lines |
| ce_fast_n | output | 1 | Fast slave enable, active low |
| ce_slow_n | output | 1 | Slow slave enable, active low |
| ce_boot_n | output | 1 | Boot memory enable, active low |

## Verification
Two things can fall in the same clock. One is the done pulse that closes a write. The other is the acceptance of the next request, because that done clock is already idle. The bench provokes this by issuing a follow-up request in the done clock of a slow-slave write. The reference model then expects the new transfer's first byte window on the very next clock, with no lost or repeated done pulse. A second overlap comes from junk requests held valid during a busy transfer. The model expects them to leave every output unchanged.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  typedef enum logic [1:0] {
    SL_FAST = 2'd0,
    SL_SLOW = 2'd1,
    SL_BOOT = 2'd2
  } slave_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_TURN  = 3'd1,
    ST_ACT   = 3'd2,
    ST_GAP   = 3'd3,
    ST_RECOV = 3'd4
  } seq_state_e;

  // Select code to slave: codes 2 and 3 both reach the boot memory.
  function automatic slave_e decode_sel(input logic [1:0] code);
    case (code)
      2'd0:    return SL_FAST;
      2'd1:    return SL_SLOW;
      default: return SL_BOOT;
    endcase
  endfunction

  // Clocks per byte window for a slave.
  function automatic int unsigned window_len(input slave_e s, input int unsigned wf,
                                             input int unsigned ws, input int unsigned wb);
    case (s)
      SL_FAST: return wf;
      SL_SLOW: return ws;
      default: return wb;
    endcase
  endfunction

  // Boot memory is read-only: any request to it becomes a read.
  function automatic logic eff_read(input slave_e s, input logic rd);
    return rd | (s == SL_BOOT);
  endfunction

  // Slaves that need an enable strobe per byte.
  function automatic logic needs_strobe(input slave_e s);
    return s != SL_FAST;
  endfunction

endpackage

// File: rtl/pbus_timer.sv
module pbus_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val))); // R6
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int LW        = 2,
  parameter int CW        = 4,
  parameter int WAIT_FAST = 1,
  parameter int WAIT_SLOW = 4,
  parameter int WAIT_BOOT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  slave_e        in_sel,
  input  logic          in_rd,
  input  logic [LW-1:0] in_len,
  input  logic          expired,
  output seq_state_e    state,
  output slave_e        sel_q,
  output logic          rd_q,
  output logic [LW-1:0] idx,
  output logic          last_byte,
  output logic          byte_end,
  output logic          load,
  output logic [CW-1:0] load_val,
  output logic          done
);
  seq_state_e    nxt;
  logic [LW-1:0] len_q;

  assign byte_end  = (state == ST_ACT) && expired;
  assign last_byte = (idx == len_q);

  always_comb begin
    nxt  = state;
    load = 1'b0;
    case (state)
      ST_IDLE: if (accept) begin
        nxt  = in_rd ? ST_TURN : ST_ACT;
        load = !in_rd;
      end
      ST_TURN: begin
        nxt  = ST_ACT;
        load = 1'b1;
      end
      ST_ACT: if (byte_end) begin
        if (last_byte)                nxt  = rd_q ? ST_RECOV : ST_IDLE;
        else if (needs_strobe(sel_q)) nxt  = ST_GAP;
        else                          load = 1'b1;
      end
      ST_GAP: begin
        nxt  = ST_ACT;
        load = 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    if (state == ST_IDLE)
      load_val = CW'(window_len(in_sel, WAIT_FAST, WAIT_SLOW, WAIT_BOOT) - 1);
    else
      load_val = CW'(window_len(sel_q, WAIT_FAST, WAIT_SLOW, WAIT_BOOT) - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      sel_q <= SL_FAST;
      rd_q  <= 1'b0;
      len_q <= '0;
      idx   <= '0;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= byte_end && last_byte;
      if (accept) begin
        sel_q <= in_sel;
        rd_q  <= in_rd;
        len_q <= in_len;
        idx   <= '0;
      end else if (byte_end && !last_byte) begin
        idx <= idx + 1'b1;
      end
    end
  end

  AST_GAP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GAP) |=> (state == ST_ACT)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
endmodule

// File: rtl/pbus_datapath.sv
module pbus_datapath #(
  parameter int NB = 4,
  parameter int LW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic [8*NB-1:0] wdata,
  input  logic [LW-1:0]   idx,
  input  logic            capture,
  input  logic [7:0]      din,
  output logic [7:0]      dout,
  output logic [8*NB-1:0] rdata
);
  logic [8*NB-1:0] wdata_q;
  logic [7:0]      wbytes [NB];

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign wbytes[g] = wdata_q[8*g +: 8];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          rdata[8*g +: 8] <= '0;
      else if (accept)                     rdata[8*g +: 8] <= '0;
      else if (capture && idx == LW'(g))   rdata[8*g +: 8] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wdata_q <= '0;
    else if (accept) wdata_q <= wdata;
  end

  assign dout = wbytes[idx];

  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(wdata_q)); // R1
endmodule

// File: rtl/pbus_master.sv
module pbus_master
  import pbus_pkg::*;
#(
  parameter int MAX_BYTES = 4,
  parameter int WAIT_FAST = 1,
  parameter int WAIT_SLOW = 4,
  parameter int WAIT_BOOT = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [1:0]             req_sel,
  input  logic                   req_rd,
  input  logic [$clog2(MAX_BYTES)-1:0] req_len,
  input  logic [2:0]             req_ctl,
  input  logic [8*MAX_BYTES-1:0] req_wdata,
  output logic                   rsp_done,
  output logic [8*MAX_BYTES-1:0] rsp_rdata,
  output logic [7:0]             bus_dout,
  input  logic [7:0]             bus_din,
  output logic                   bus_oe,
  output logic                   bus_rd,
  output logic [2:0]             bus_ctl,
  output logic                   ce_fast_n,
  output logic                   ce_slow_n,
  output logic                   ce_boot_n
);
  localparam int LW    = $clog2(MAX_BYTES);
  localparam int WMAX  = (WAIT_BOOT > WAIT_SLOW) ?
                         ((WAIT_BOOT > WAIT_FAST) ? WAIT_BOOT : WAIT_FAST) :
                         ((WAIT_SLOW > WAIT_FAST) ? WAIT_SLOW : WAIT_FAST);
  localparam int CW    = $clog2(WMAX + 1);

  seq_state_e    state;
  slave_e        in_sel, sel_q;
  logic          in_rd, rd_q, accept, expired, load, last_byte, byte_end, capture;
  logic [CW-1:0] load_val;
  logic [LW-1:0] idx;
  logic [2:0]    ctl_q;
  logic          in_window, in_burst;

  assign in_sel    = decode_sel(req_sel);
  assign in_rd     = eff_read(in_sel, req_rd);
  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign capture   = byte_end && rd_q;

  pbus_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .expired(expired)
  );

  pbus_seq #(
    .LW(LW), .CW(CW),
    .WAIT_FAST(WAIT_FAST), .WAIT_SLOW(WAIT_SLOW), .WAIT_BOOT(WAIT_BOOT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .in_sel(in_sel), .in_rd(in_rd),
    .in_len(req_len), .expired(expired), .state(state), .sel_q(sel_q), .rd_q(rd_q),
    .idx(idx), .last_byte(last_byte), .byte_end(byte_end), .load(load),
    .load_val(load_val), .done(rsp_done)
  );

  pbus_datapath #(.NB(MAX_BYTES), .LW(LW)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .wdata(req_wdata), .idx(idx),
    .capture(capture), .din(bus_din), .dout(bus_dout), .rdata(rsp_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (accept) ctl_q <= req_ctl;
  end

  assign in_window = (state == ST_ACT);
  assign in_burst  = (state == ST_ACT) || (state == ST_GAP);
  assign bus_ctl   = ctl_q;
  assign bus_rd    = in_burst && rd_q;
  assign bus_oe    = (state == ST_IDLE) || (in_burst && !rd_q);
  assign ce_fast_n = !(in_window && sel_q == SL_FAST);
  assign ce_slow_n = !(in_window && sel_q == SL_SLOW);
  assign ce_boot_n = !(in_window && sel_q == SL_BOOT);

  AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~ce_fast_n, ~ce_slow_n, ~ce_boot_n})); // R3
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_oe && bus_rd)); // R7
  AST_TURN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd) |-> !$past(bus_oe)); // R7
  AST_FAST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_fast_n && byte_end && !last_byte) |=> !ce_fast_n); // R4
  AST_SLOW_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_slow_n && byte_end && !last_byte) |=> ce_slow_n); // R5
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R1
  AST_BOOT_READS: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_boot_n |-> (bus_rd && !bus_oe)); // R10
  AST_CTL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_window && $past(in_window)) |-> $stable(bus_ctl)); // R11
endmodule

// File: tb/tb_pbus_master.sv
module tb_pbus_master;
  typedef struct packed {
    logic [2:0]  ce;     // bit0 fast, bit1 slow, bit2 boot, active low
    logic        rd;
    logic        oe;
    logic        rdy;
    logic        done;
    logic        cmpd;
    logic [7:0]  dout;
    logic [2:0]  ctl;
    logic [31:0] rdata;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_sel = '0;
  logic        req_rd = 1'b0;
  logic [1:0]  req_len = '0;
  logic [2:0]  req_ctl = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_done;
  logic [31:0] rsp_rdata;
  logic [7:0]  bus_dout, bus_din;
  logic        bus_oe, bus_rd;
  logic [2:0]  bus_ctl;
  logic        ce_fast_n, ce_slow_n, ce_boot_n;

  int   cyc = 0;
  int   n_checks = 0;
  int   n_fail = 0;
  bit   run = 1'b0;
  exp_t exp_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Slave model: returned byte depends only on the clock number.
  assign bus_din = 8'(cyc * 7) ^ 8'h5A;

  pbus_master dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_sel(req_sel), .req_rd(req_rd), .req_len(req_len), .req_ctl(req_ctl),
    .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .bus_dout(bus_dout), .bus_din(bus_din), .bus_oe(bus_oe), .bus_rd(bus_rd),
    .bus_ctl(bus_ctl), .ce_fast_n(ce_fast_n), .ce_slow_n(ce_slow_n), .ce_boot_n(ce_boot_n)
  );

  function automatic int din_at(input int c);
    return int'(8'(c * 7) ^ 8'h5A);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (run) begin
      exp_t e;
      logic [2:0] ce_now;
      if (exp_q.size() != 0) e = exp_q.pop_front();
      else e = '{ce: 3'b111, rd: 1'b0, oe: 1'b1, rdy: 1'b1, done: 1'b0,
                 cmpd: 1'b0, dout: '0, ctl: '0, rdata: '0};
      ce_now = {ce_boot_n, ce_slow_n, ce_fast_n};
      chk(ce_now == e.ce, "R3 R4 R5 R6 chip enables", 32'(ce_now), 32'(e.ce));
      chk(bus_rd == e.rd, "R2 R7 R10 direction", 32'(bus_rd), 32'(e.rd));
      chk(bus_oe == e.oe, "R7 output enable", 32'(bus_oe), 32'(e.oe));
      chk(req_ready == e.rdy, "R1 ready", 32'(req_ready), 32'(e.rdy));
      chk(rsp_done == e.done, "R9 done", 32'(rsp_done), 32'(e.done));
      if (e.cmpd) chk(bus_dout == e.dout, "R2 write byte", 32'(bus_dout), 32'(e.dout));
      if (e.ce != 3'b111) chk(bus_ctl == e.ctl, "R11 control code", 32'(bus_ctl), 32'(e.ctl));
      if (e.done) chk(rsp_rdata == e.rdata, "R8 read word", rsp_rdata, e.rdata);
    end
  end

  // Reference model: expected outputs for each clock after acceptance.
  function automatic int build(input int n, input int sel, input bit rd, input int nb,
                               input logic [2:0] ctl, input logic [31:0] wd);
    int s, w, k;
    bit r;
    logic [31:0] rw;
    exp_t e;
    s  = (sel >= 2) ? 2 : sel;
    r  = rd || (s == 2);                       // R10
    w  = (s == 0) ? 1 : (s == 1) ? 4 : 8;      // R6
    k  = 0;
    rw = '0;
    e  = '0;
    if (r) begin
      e = '{ce: 3'b111, rd: 0, oe: 0, rdy: 0, done: 0, cmpd: 0, dout: 0, ctl: 0, rdata: 0};
      exp_q.push_back(e); k++;
    end
    for (int i = 0; i < nb; i++) begin
      if (i > 0 && s != 0) begin
        e = '{ce: 3'b111, rd: r, oe: !r, rdy: 0, done: 0, cmpd: 0, dout: 0, ctl: 0, rdata: 0};
        exp_q.push_back(e); k++;
      end
      for (int j = 0; j < w; j++) begin
        e = '{ce: ~(3'b001 << s), rd: r, oe: !r, rdy: 0, done: 0, cmpd: !r,
              dout: wd[8*i +: 8], ctl: ctl, rdata: 0};
        if (r && j == w - 1) rw[8*i +: 8] = 8'(din_at(n + 1 + k));
        exp_q.push_back(e); k++;
      end
    end
    if (r) e = '{ce: 3'b111, rd: 0, oe: 0, rdy: 0, done: 1, cmpd: 0, dout: 0, ctl: 0, rdata: rw};
    else   e = '{ce: 3'b111, rd: 0, oe: 1, rdy: 1, done: 1, cmpd: 0, dout: 0, ctl: 0, rdata: 0};
    exp_q.push_back(e); k++;
    return k;
  endfunction

  task automatic issue(input int sel, input bit rd, input int nb, input logic [2:0] ctl,
                       input logic [31:0] wd, input bit noise, input bit b2b);
    int len;
    if (!b2b) begin @(negedge clk); #1; end
    req_valid = 1'b1;
    req_sel   = 2'(sel);
    req_rd    = rd;
    req_len   = 2'(nb - 1);
    req_ctl   = ctl;
    req_wdata = wd;
    len = build(cyc, sel, rd, nb, ctl, wd);
    for (int j = 1; j < len; j++) begin
      @(negedge clk); #1;
      req_valid = noise;                       // R1: ignored while busy
      req_sel   = 2'(j);
      req_rd    = ~rd;
      req_len   = 2'(j + 1);
      req_ctl   = ~ctl;
      req_wdata = ~wd;
    end
    @(negedge clk); #1;
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk({ce_boot_n, ce_slow_n, ce_fast_n} == 3'b111, "R12 enables in reset",
        32'({ce_boot_n, ce_slow_n, ce_fast_n}), 32'h7);
    chk(!bus_rd && bus_oe, "R12 direction/oe in reset", 32'({bus_rd, bus_oe}), 32'h1);
    chk(req_ready && !rsp_done, "R12 ready/done in reset", 32'({req_ready, rsp_done}), 32'h2);
    #1 rst_n = 1'b1;
    run = 1'b1;
    repeat (2) @(negedge clk);
    issue(0, 0, 1, 3'b000, 32'h0000_0042, 0, 0);  // R11 preamble code 000
    issue(0, 0, 4, 3'b010, 32'hA1B2_C3D4, 0, 0);  // R2 R4 fast burst
    issue(1, 0, 3, 3'b001, 32'h0011_2233, 0, 0);  // R5 R6 slow strobes
    issue(0, 1, 2, 3'b011, 32'h0, 0, 0);          // R7 R8 fast read
    issue(1, 1, 4, 3'b101, 32'h0, 1, 0);          // R1 noise during slow read
    issue(2, 0, 2, 3'b110, 32'hDEAD_BEEF, 0, 0);  // R10 boot write runs as read
    issue(3, 1, 1, 3'b111, 32'h0, 0, 0);          // R3 code 3 reaches boot
    issue(1, 0, 2, 3'b100, 32'h0000_5566, 1, 0);  // R1 noise during slow write
    issue(0, 0, 3, 3'b010, 32'h0077_8899, 0, 1);  // R9 taken in done clock
    issue(0, 1, 4, 3'b001, 32'h0, 0, 0);          // R8 four-byte fast read
    repeat (4) @(negedge clk);
    run = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule